// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. It takes a serial line and a 16x oversampling tick, and it rebuilds frames of one of two kinds: a start bit, eight data bits sent least significant bit first, and a stop bit; or the same frame with an extra ninth bit placed before the stop bit. Each bit is decided by a majority vote over three ticks around its middle. When a frame is accepted, the block loads the byte and the extra bit into holding registers and raises a sticky receive flag. Software clears that flag with a one-cycle clear strobe.

A multiprocessor enable bit limits which frames raise the flag. In the 9-bit modes, a frame with the ninth bit at 0 is treated as data and is ignored. A frame with the ninth bit at 1 is treated as an address. It is taken only if it matches the node's given address or its broadcast address. Both addresses are built from an address register and a mask register. In the 8-bit mode, the same enable makes the flag depend on a valid stop bit. A separate sticky flag reports any frame whose stop bit sampled low.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_data`, `rx_bit9`, `rx_flag` and `frame_err` are all 0.
- R2: With `mode` = 2'b01 (8-bit frame) and `mp_en` = 0, a frame with start 0, eight data bits LSB first and a stop bit loads the byte into `rx_data`, loads the sampled stop bit into `rx_bit9`, and sets `rx_flag`.
- R3: With `mode` = 2'b10 or 2'b11 (9-bit frames) and `mp_en` = 0, every frame loads its byte into `rx_data`, loads its ninth bit into `rx_bit9`, and sets `rx_flag`.
- R4: In a 9-bit mode with `mp_en` = 1, a frame whose ninth bit is 0 leaves `rx_flag`, `rx_data` and `rx_bit9` unchanged.
- R5: In a 9-bit mode with `mp_en` = 1 and the ninth bit at 1, the frame is accepted only in two cases. The first is a given-address match: for every bit i where `slave_mask`[i] = 1, the received bit i equals `slave_addr`[i]. The second is a broadcast match: every bit set in (`slave_addr` | `slave_mask`) is 1 in the received byte. With both registers at zero, every address is accepted.
- R6: In the 8-bit mode with `mp_en` = 1, a frame is accepted only when its stop bit samples as 1.
- R7: `frame_err` goes to 1 at the end of any received frame whose stop bit sampled 0, whether or not the frame is accepted. It stays at 1 until `err_clr` is pulsed.
- R8: No frame is received while `rx_en` = 0 or while `mode` = 2'b00.
- R9: `rx_flag` stays at 1 until `flag_clr` is pulsed. While it is 1, a further frame does not change `rx_data` or `rx_bit9`.
- R10: Each bit is taken as the majority of three samples at oversampling ticks 7, 8 and 9 of the bit. A start bit that votes high returns the receiver to idle without producing a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| mode | input | 2 | Frame mode: 00 off, 01 8-bit, 10/11 9-bit |
| rx_en | input | 1 | Receive enable |
| mp_en | input | 1 | Multiprocessor filtering enable |
| flag_clr | input | 1 | Clears `rx_flag` |
| err_clr | input | 1 | Clears `frame_err` |
| slave_addr | input | 8 | Node address register |
| slave_mask | input | 8 | Address mask register |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (9-bit modes) or stop bit (8-bit mode) of the last accepted frame |
| rx_flag | output | 1 | Sticky receive flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Directed frames use the overlapping mask examples. These tell a given-address hit, a broadcast-only hit and a rejection apart, and they show that data frames are dropped by the ninth bit. Stop-bit-low frames are sent in the 8-bit mode with filtering on and with filtering off. This separates the acceptance rule from the framing-error flag. Single-tick glitches are placed on one sample point of a data bit and on a short start pulse. They show the majority vote and the return to idle after a false start. Constrained random frames then vary mode, filter enable, register pair, byte, ninth bit and stop bit. An independent bench model of the match predicts acceptance and the values that should be held.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT = 2'b00,
    MD_BYTE  = 2'b01,
    MD_NINE0 = 2'b10,
    MD_NINE1 = 2'b11
  } rx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;

  // two-of-three vote used for every bit decision
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mp_rx_sync.sv
module mp_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mp_rx_frame.sv
module mp_rx_frame
  import mp_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic              active_i,
  input  logic              nine_i,
  output logic              frame_end_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] SMP_B = CW'(OSR / 2);
  localparam logic [CW-1:0] SMP_A = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] SMP_C = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [IW-1:0] IDX_END = IW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              b9_q, stop_q, smp_a_q, smp_b_q, end_q;

  // named internal events
  logic vote_w, decide_w, bit_done_w, start_glitch_w;
  assign vote_w         = maj3(smp_a_q, smp_b_q, line_i);
  assign decide_w       = tick_i && (state_q != ST_IDLE) && (cnt_q == SMP_C);
  assign bit_done_w     = tick_i && (state_q != ST_IDLE) && (cnt_q == LAST);
  assign start_glitch_w = decide_w && (state_q == ST_START) && vote_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      b9_q    <= 1'b0;
      stop_q  <= 1'b0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
      end_q   <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (!active_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!line_i) begin
            state_q <= ST_START;
            cnt_q   <= CW'(1);
          end
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
          if (cnt_q == SMP_A) smp_a_q <= line_i;
          if (cnt_q == SMP_B) smp_b_q <= line_i;
          if (decide_w) begin
            case (state_q)
              ST_START: if (vote_w) state_q <= ST_IDLE;
              ST_DATA:  shift_q <= {vote_w, shift_q[DATA_W-1:1]};
              ST_NINTH: b9_q    <= vote_w;
              ST_STOP:  stop_q  <= vote_w;
              default:  ;
            endcase
          end
          if (bit_done_w) begin
            case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ST_DATA: begin
                if (idx_q == IDX_END) state_q <= nine_i ? ST_NINTH : ST_STOP;
                else                  idx_q   <= idx_q + IW'(1);
              end
              ST_NINTH: state_q <= ST_STOP;
              ST_STOP: begin
                state_q <= ST_IDLE;
                end_q   <= 1'b1;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign frame_end_o = end_q;
  assign data_o      = shift_q;
  assign bit9_o      = b9_q;
  assign stop_o      = stop_q;

  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_glitch_w && active_i) |=> (state_q == ST_IDLE && !frame_end_o)); // R10

  AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !end_q) |=> !frame_end_o); // R8
endmodule

// File: rtl/mp_rx_accept.sv
module mp_rx_accept #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end_i,
  input  logic [1:0]        mode_i,
  input  logic              mp_en_i,
  input  logic              flag_clr_i,
  input  logic              err_clr_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_flag_o,
  output logic              frame_err_o
);
  // masked compare against the node's own address
  function automatic logic given_hit(input logic [DATA_W-1:0] rx,
                                     input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] m);
    return (rx & m) == (a & m);
  endfunction

  // every one in (a | m) must be a one in rx
  function automatic logic bcast_hit(input logic [DATA_W-1:0] rx,
                                     input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] m);
    return (rx & (a | m)) == (a | m);
  endfunction

  logic nine_w, addr_ok_w, accept_w, load_w, ninth_val_w;
  assign nine_w      = mode_i[1];
  assign addr_ok_w   = given_hit(data_i, addr_i, mask_i) || bcast_hit(data_i, addr_i, mask_i);
  assign accept_w    = nine_w ? (!mp_en_i || (bit9_i && addr_ok_w))
                              : (!mp_en_i || stop_i);
  assign load_w      = frame_end_i && accept_w && !rx_flag_o;
  assign ninth_val_w = nine_w ? bit9_i : stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_o   <= '0;
      rx_bit9_o   <= 1'b0;
      rx_flag_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      if (flag_clr_i) rx_flag_o <= 1'b0;
      if (load_w) begin
        rx_data_o <= data_i;
        rx_bit9_o <= ninth_val_w;
        rx_flag_o <= 1'b1;
      end
      if (err_clr_i)                frame_err_o <= 1'b0;
      if (frame_end_i && !stop_i)   frame_err_o <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_o && !flag_clr_i) |=> rx_flag_o); // R9

  AST_FLAG_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_flag_o && !frame_end_i) |=> !rx_flag_o); // R2

  AST_DATA_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && nine_w && mp_en_i && !bit9_i) |=> ($stable(rx_data_o) && $stable(rx_bit9_o))); // R4

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && rx_flag_o) |=> $stable(rx_data_o)); // R9

  AST_FERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_err_o && !(frame_end_i && !stop_i)) |=> !frame_err_o); // R7
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OSR       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic [1:0]        mode,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic              flag_clr,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] slave_addr,
  input  logic [DATA_W-1:0] slave_mask,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              frame_err
);
  import mp_rx_pkg::*;

  logic              line_s, active_w, frame_end_w, bit9_w, stop_w;
  logic [DATA_W-1:0] data_w;

  assign active_w = rx_en && (rx_mode_e'(mode) != MD_SHIFT);

  mp_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_line), .q_o(line_s)
  );

  mp_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .tick_i(os_tick),
    .active_i(active_w), .nine_i(mode[1]), .frame_end_o(frame_end_w),
    .data_o(data_w), .bit9_o(bit9_w), .stop_o(stop_w)
  );

  mp_rx_accept #(.DATA_W(DATA_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_w), .mode_i(mode),
    .mp_en_i(mp_en), .flag_clr_i(flag_clr), .err_clr_i(err_clr),
    .addr_i(slave_addr), .mask_i(slave_mask), .data_i(data_w),
    .bit9_i(bit9_w), .stop_i(stop_w), .rx_data_o(rx_data),
    .rx_bit9_o(rx_bit9), .rx_flag_o(rx_flag), .frame_err_o(frame_err)
  );

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_w && !frame_end_w && !rx_flag) |=> !rx_flag); // R8
endmodule

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic rx_en = 1'b0, mp_en = 1'b0, flag_clr = 1'b0, err_clr = 1'b0;
  logic [7:0] slave_addr = 8'h00, slave_mask = 8'h00;
  logic [7:0] rx_data;
  logic rx_bit9, rx_flag, frame_err;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_data = 8'h00;
  logic exp_b9 = 1'b0;

  always #5 clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    os_tick <= (tick_cnt == 0);
  end

  mp_uart_rx u_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick), .mode(mode),
    .rx_en(rx_en), .mp_en(mp_en), .flag_clr(flag_clr), .err_clr(err_clr),
    .slave_addr(slave_addr), .slave_mask(slave_mask), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_flag(rx_flag), .frame_err(frame_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rx_line = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic [7:0] d, input logic b9, input logic stp);
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold_line(d[i], BITCLK);
    if (nine) hold_line(b9, BITCLK);
    hold_line(stp, BITCLK);
    hold_line(1'b1, 3 * BITCLK);
  endtask

  task automatic pulse_clear();
    flag_clr = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; err_clr = 1'b0;
    @(negedge clk);
  endtask

  // independent acceptance model, bit by bit
  function automatic bit model_accept(input logic [1:0] md, input logic sm2,
      input logic [7:0] d, input logic b9, input logic stp,
      input logic [7:0] a, input logic [7:0] m);
    bit g = 1, b = 1;
    for (int i = 0; i < 8; i++) begin
      if (m[i] && d[i] != a[i]) g = 0;
      if ((a[i] || m[i]) && !d[i]) b = 0;
    end
    if (!sm2) return 1;
    if (md == 2'b01) return stp;
    return b9 && (g || b);
  endfunction

  task automatic frame_check(input string req, input logic [1:0] md, input logic sm2,
      input logic [7:0] d, input logic b9, input logic stp);
    bit acc;
    pulse_clear();
    mode = md; mp_en = sm2;
    acc = model_accept(md, sm2, d, b9, stp, slave_addr, slave_mask);
    send(md[1], d, b9, stp);
    if (acc) begin exp_data = d; exp_b9 = md[1] ? b9 : stp; end
    chk(req, {31'd0, rx_flag}, {31'd0, acc});
    chk(req, {24'd0, rx_data}, {24'd0, exp_data});
    chk(req, {31'd0, rx_bit9}, {31'd0, exp_b9});
    chk(req, {31'd0, frame_err}, {31'd0, ~stp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", {21'd0, rx_data, rx_bit9, rx_flag, frame_err}, 32'd0);
    rst_n = 1'b1; rx_en = 1'b1;
    repeat (4) @(negedge clk);

    frame_check("R2", 2'b01, 0, 8'hA5, 0, 1);
    frame_check("R2_R7", 2'b01, 0, 8'h5A, 0, 0);
    pulse_clear();
    chk("R7 cleared", {31'd0, frame_err}, 32'd0);
    frame_check("R6", 2'b01, 1, 8'h33, 0, 0);
    frame_check("R6", 2'b01, 1, 8'h81, 0, 1);
    frame_check("R3", 2'b10, 0, 8'h3C, 0, 1);
    frame_check("R3", 2'b11, 0, 8'hC3, 1, 1);
    frame_check("R4", 2'b11, 1, 8'h77, 0, 1);
    slave_addr = 8'hC0; slave_mask = 8'hFD;
    frame_check("R5 given", 2'b10, 1, 8'hC2, 1, 1);
    frame_check("R5 reject", 2'b11, 1, 8'hC1, 1, 1);
    frame_check("R5 bcast", 2'b11, 1, 8'hFD, 1, 1);
    slave_addr = 8'hE0; slave_mask = 8'hFA;
    frame_check("R5 reject", 2'b11, 1, 8'hE2, 1, 1);
    frame_check("R5 given", 2'b11, 1, 8'hE5, 1, 1);
    slave_addr = 8'h00; slave_mask = 8'h00;
    frame_check("R5 zero regs", 2'b10, 1, 8'h12, 1, 1);

    // R8: receive disabled, then mode 00
    pulse_clear();
    rx_en = 1'b0; mode = 2'b01; mp_en = 0;
    send(1'b0, 8'h99, 0, 1);
    chk("R8 rx_en off flag", {31'd0, rx_flag}, 32'd0);
    chk("R8 rx_en off data", {24'd0, rx_data}, {24'd0, exp_data});
    rx_en = 1'b1; mode = 2'b00;
    send(1'b0, 8'h66, 0, 0);
    chk("R8 mode00 flag", {31'd0, rx_flag}, 32'd0);
    chk("R8 mode00 ferr", {31'd0, frame_err}, 32'd0);

    // R9: overrun keeps the held byte; flag sticks until clear
    mode = 2'b01;
    send(1'b0, 8'h4E, 0, 1);
    exp_data = 8'h4E; exp_b9 = 1'b1;
    send(1'b0, 8'hB1, 0, 1);
    chk("R9 sticky", {31'd0, rx_flag}, 32'd1);
    chk("R9 no overwrite", {24'd0, rx_data}, {24'd0, exp_data});
    pulse_clear();
    chk("R9 cleared", {31'd0, rx_flag}, 32'd0);

    // R10: one-tick glitch on the middle sample of data bit 3
    pulse_clear();
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        hold_line(1'b1, 30); hold_line(1'b0, 4); hold_line(1'b1, BITCLK - 34);
      end else hold_line(8'hCF >> i, BITCLK);
    end
    hold_line(1'b1, 4 * BITCLK);
    chk("R10 vote", {24'd0, rx_data}, 32'hCF);
    // R10: short start pulse rejected
    pulse_clear();
    hold_line(1'b0, 16);
    hold_line(1'b1, 12 * BITCLK);
    chk("R10 false start flag", {31'd0, rx_flag}, 32'd0);
    chk("R10 false start data", {24'd0, rx_data}, 32'hCF);
    exp_data = 8'hCF; exp_b9 = 1'b1;

    // constrained random frames, R2 R3 R5 R6 R7
    for (int n = 0; n < 36; n++) begin
      logic [1:0] md;
      md = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 3) == 0) begin slave_addr = 0; slave_mask = 0; end
      else begin slave_addr = 8'($urandom); slave_mask = 8'($urandom); end
      frame_check("R5 random", md, 1'($urandom), 8'($urandom), 1'($urandom),
                  ($urandom_range(0, 4) != 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule